// File: doc/BRIEF.md
# Strobed Serial Register Port

This block is the logic-device side of a serial register port with no chip select. A host drives a serial clock, a data line into the block and an active-low strobe, and reads a data line back. All three host lines pass through two-flop synchronisers into the fast system clock. Edges of the serial clock are found from the synchronised copies.

Each rising serial-clock edge with the strobe high shifts one bit into a 40-bit frame register. The one rising edge that arrives while the strobe is low is the commit edge. The data level on that edge picks the operation. A write takes its address from the low 8 frame bits and its data from the upper 32. A read takes its address from the low 8 bits, loads the addressed value into an output shifter and then returns it most significant bit first.

The block holds five registers. Mode and multiplexer are read/write and drive output buses. The reset register is read/write and raises a one-cycle reset request when the value 1 is written to it. Switch inputs and version are read-only.

Top module: `strobed_reg_port`

## Requirements
- R1: After reset, modeOut and muxOut are zero, resetReq is low and misoOut is low.
- R2: A write frame is 32 data bits then 8 address bits, both MSB first, captured on rising serial-clock edges with the strobe high. A rising edge with the strobe low and data-in 1 commits the write.
- R3: A read is 8 address bits, then a commit edge with data-in 0. The addressed 32-bit value appears on misoOut MSB first. The MSB is valid before the next rising edge, and the output advances one bit on each falling edge that occurs with the strobe high.
- R4: Address 0x00 is the mode register and 0x02 is the multiplexer register. Both are read/write, and their contents appear on modeOut and muxOut.
- R5: Address 0x08 reads the switchIn bus, zero-extended. Address 0xFF reads the VERSION parameter.
- R6: Writes to 0x08, 0xFF or any unmapped address change no register and cause no reset request.
- R7: Reads of unmapped addresses return zero.
- R8: A write to 0x80 stores the value, which reads back. resetReq pulses for exactly one system-clock cycle only when the written value equals 1.
- R9: A read, including a start-up read of the version register, changes no register and raises no reset request.
- R10: Rising edges with the strobe high never commit. A full write frame shifted without a strobe leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Host serial clock (asynchronous) |
| mosiIn | input | 1 | Host data into the block |
| strobeNIn | input | 1 | Host commit strobe, active low, idles high |
| switchIn | input | SW_W | Switch input levels |
| misoOut | output | 1 | Serial data back to the host |
| modeOut | output | 32 | Mode register contents |
| muxOut | output | 32 | Multiplexer register contents |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
A frame register that drops or duplicates a bit shows up as a wrong address or wrong data on the next commit. The bench sees this at modeOut or muxOut three system clocks after the commit edge, or in the read-back word. An output shifter that advances on the commit edge's own falling edge returns the read word shifted by one bit from the first sampled bit onward. A commit raised without the strobe alters a register visible on the output buses during a strobe-free frame. Spurious reset requests are counted at the port for every operation.

// File: rtl/strobed_reg_pkg.sv
package strobed_reg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MUX     = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_SWITCH  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_RESET   = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_VERSION = 8'hFF;

  typedef struct packed {
    logic shiftEn;   // rising edge, strobe high: take one frame bit
    logic writeCmd;  // commit edge, data-in high
    logic readCmd;   // commit edge, data-in low
    logic advance;   // falling edge, strobe high: next read bit
  } ctlStrobes_t;
endpackage

// File: rtl/strobed_reg_sync.sv
module strobed_reg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= IDLE;
      syncOut <= IDLE;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/strobed_reg_ctrl.sv
module strobed_reg_ctrl
  import strobed_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckS,
  input  logic        mosiS,
  input  logic        strobeNS,
  output ctlStrobes_t ctl
);
  logic sckPrev;
  logic sckRise;
  logic sckFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;

  always_comb begin
    ctl          = '0;
    ctl.shiftEn  = sckRise & strobeNS;
    ctl.writeCmd = sckRise & ~strobeNS & mosiS;
    ctl.readCmd  = sckRise & ~strobeNS & ~mosiS;
    ctl.advance  = sckFall & strobeNS;
  end
endmodule

// File: rtl/strobed_reg_dp.sv
module strobed_reg_dp
  import strobed_reg_pkg::*;
#(
  parameter int SW_W = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              mosiS,
  input  logic [SW_W-1:0]   switchIn,
  output logic [DATA_W-1:0] modeReg,
  output logic [DATA_W-1:0] muxReg,
  output logic [DATA_W-1:0] outWord,
  output logic              resetReq
);
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  wrData;
  logic [DATA_W-1:0]  rstReg;
  logic [DATA_W-1:0]  rdValue;

  assign addr   = frame[ADDR_W-1:0];
  assign wrData = frame[FRAME_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           frame <= '0;
    else if (ctl.shiftEn) frame <= {frame[FRAME_W-2:0], mosiS};
  end

  always_comb begin
    case (addr)
      ADR_MODE:    rdValue = modeReg;
      ADR_MUX:     rdValue = muxReg;
      ADR_SWITCH:  rdValue = DATA_W'(switchIn);
      ADR_RESET:   rdValue = rstReg;
      ADR_VERSION: rdValue = VERSION;
      default:     rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      muxReg   <= '0;
      rstReg   <= '0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (ctl.writeCmd) begin
        case (addr)
          ADR_MODE:  modeReg <= wrData;
          ADR_MUX:   muxReg  <= wrData;
          ADR_RESET: begin
            rstReg   <= wrData;
            resetReq <= (wrData == DATA_W'(1));
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outWord <= '0;
    else if (ctl.readCmd) outWord <= rdValue;
    else if (ctl.advance) outWord <= {outWord[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/strobed_reg_port.sv
module strobed_reg_port
  import strobed_reg_pkg::*;
#(
  parameter int SW_W = 8,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sckIn,
  input  logic            mosiIn,
  input  logic            strobeNIn,
  input  logic [SW_W-1:0] switchIn,
  output logic            misoOut,
  output logic [31:0]     modeOut,
  output logic [31:0]     muxOut,
  output logic            resetReq
);
  logic [2:0]        syncVec;
  ctlStrobes_t       ctl;
  logic [DATA_W-1:0] outWord;

  strobed_reg_sync #(.W(3), .IDLE(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({strobeNIn, mosiIn, sckIn}),
    .syncOut(syncVec)
  );

  strobed_reg_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sckS(syncVec[0]), .mosiS(syncVec[1]), .strobeNS(syncVec[2]),
    .ctl(ctl)
  );

  strobed_reg_dp #(.SW_W(SW_W), .VERSION(VERSION)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mosiS(syncVec[1]),
    .switchIn(switchIn), .modeReg(modeOut), .muxReg(muxOut),
    .outWord(outWord), .resetReq(resetReq)
  );

  assign misoOut = outWord[DATA_W-1];
endmodule

// File: rtl/strobed_reg_port_chk.sv
module strobed_reg_port_chk
  import strobed_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input ctlStrobes_t       ctl,
  input logic [31:0]       modeOut,
  input logic [31:0]       muxOut,
  input logic              resetReq,
  input logic [DATA_W-1:0] outWord
);
  // R8: request lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R8, R9: request only follows a write commit
  a_r8_req_after_write: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(ctl.writeCmd));
  // R10: mode changes only after a write commit
  a_r10_mode_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeOut) |-> $past(ctl.writeCmd));
  // R10: mux changes only after a write commit
  a_r10_mux_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxOut) |-> $past(ctl.writeCmd));
  // R3: output shifter moves only on read commit or advance
  a_r3_out_moves: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outWord) |-> $past(ctl.readCmd || ctl.advance));
  // R2: strobes mutually exclusive
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftEn, ctl.writeCmd, ctl.readCmd, ctl.advance}));
endmodule

bind strobed_reg_port strobed_reg_port_chk uChk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .modeOut(modeOut), .muxOut(muxOut),
  .resetReq(resetReq), .outWord(outWord)
);

// File: tb/strobed_reg_port_test.sv
module strobed_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [31:0] VER = 32'hA5C3_0107;

  logic clk = 0, rstN = 0, sck = 0, mosi = 0, strobeN = 1;
  logic [7:0] sw = 8'h5A;
  logic miso, resetReq;
  logic [31:0] modeOut, muxOut;
  int checks = 0, fails = 0, pulses = 0, cycles = 0;

  strobed_reg_port #(.SW_W(8), .VERSION(VER)) uut (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .strobeNIn(strobeN),
    .switchIn(sw), .misoOut(miso), .modeOut(modeOut), .muxOut(muxOut),
    .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (resetReq) pulses++;
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shiftBits(logic [39:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i]; waitHalf();
      sck = 1; waitHalf();
      sck = 0;
    end
    waitHalf();
  endtask

  task automatic commit(logic isWrite);
    mosi = isWrite; strobeN = 0; waitHalf();
    sck = 1; waitHalf();
    sck = 0; waitHalf();
    strobeN = 1; mosi = 0; waitHalf();
  endtask

  task automatic writeReg(logic [7:0] a, logic [31:0] d);
    shiftBits({d, a}, 40);
    commit(1'b1);
  endtask

  task automatic readReg(logic [7:0] a, output logic [31:0] d, output logic msbEarly);
    shiftBits({32'h0, a}, 8);
    commit(1'b0);
    msbEarly = miso;
    d = '0;
    for (int i = 0; i < 32; i++) begin
      sck = 1; waitHalf();
      d = {d[30:0], miso};
      sck = 0; waitHalf();
    end
  endtask

  task automatic testReset();
    check("R1 mode", modeOut, 0);
    check("R1 mux", muxOut, 0);
    check("R1 resetReq", {31'h0, resetReq}, 0);
    check("R1 miso", {31'h0, miso}, 0);
  endtask

  task automatic testDummyRead();
    logic [31:0] d; logic m; int p0 = pulses;
    readReg(8'hFF, d, m);
    check("R5 version", d, VER);
    check("R9 mode untouched", modeOut, 0);
    check("R9 mux untouched", muxOut, 0);
    check("R9 no request", pulses, p0);
  endtask

  task automatic testWriteRead();
    logic [31:0] d; logic m;
    writeReg(8'h00, 32'h8123_4567);
    check("R2 mode write", modeOut, 32'h8123_4567);
    writeReg(8'h02, 32'h0F0F_55AA);
    check("R4 mux write", muxOut, 32'h0F0F_55AA);
    check("R4 mode kept", modeOut, 32'h8123_4567);
    readReg(8'h00, d, m);
    check("R3 mode readback", d, 32'h8123_4567);
    check("R3 msb before first rise", {31'h0, m}, 1);
    readReg(8'h02, d, m);
    check("R4 mux readback", d, 32'h0F0F_55AA);
  endtask

  task automatic testReadOnly();
    logic [31:0] d; logic m; int p0 = pulses;
    readReg(8'h08, d, m);
    check("R5 switch read", d, 32'h5A);
    writeReg(8'h08, 32'hFFFF_FFFF);
    writeReg(8'hFF, 32'h1234_0000);
    writeReg(8'h41, 32'h0000_0001);
    check("R6 mode kept", modeOut, 32'h8123_4567);
    check("R6 mux kept", muxOut, 32'h0F0F_55AA);
    check("R6 no request", pulses, p0);
    readReg(8'h08, d, m);
    check("R6 switch unchanged", d, 32'h5A);
    readReg(8'hFF, d, m);
    check("R6 version unchanged", d, VER);
    readReg(8'h41, d, m);
    check("R7 unmapped reads zero", d, 0);
  endtask

  task automatic testResetReg();
    logic [31:0] d; logic m; int p0 = pulses;
    writeReg(8'h80, 32'h0000_0005);
    check("R8 no pulse for 5", pulses, p0);
    readReg(8'h80, d, m);
    check("R8 readback 5", d, 5);
    writeReg(8'h80, 32'h0000_0001);
    check("R8 one pulse for 1", pulses, p0 + 1);
    readReg(8'h80, d, m);
    check("R8 readback 1", d, 1);
  endtask

  task automatic testNoStrobe();
    shiftBits({32'hDEAD_BEEF, 8'h00}, 40);
    check("R10 mode unchanged", modeOut, 32'h8123_4567);
    shiftBits({32'h1111_2222, 8'h02}, 40);
    check("R10 mux unchanged", muxOut, 32'h0F0F_55AA);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (4) @(negedge clk);
    testDummyRead();
    testWriteRead();
    testReadOnly();
    testResetReg();
    testNoStrobe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule